// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block controls the low-power states of a small 8-bit microcontroller core. It holds one 8-bit control register on the special-function-register bus. A software write that sets one of two mode bits sends the core into Idle or Power-down. In Idle the CPU clock enable drops and the peripheral clock enable stays high. In Power-down both enables drop.

Idle ends when an enabled interrupt is pending. Power-down ends on an external wake request. Depending on a register bit, the clocks return either at once or after a fixed warm-up count on the always-on clock. On every return to the running state the block clears the mode bit it entered with and sends a one-cycle wake pulse to the interrupt controller, so the pending interrupt is serviced at once. A power-off flag in the register is set only by a cold reset and survives warm resets. Software uses it to tell the two kinds of reset apart.

The state machine has four states:
- `ST_ACTIVE`: the core is running.
- `ST_IDLE`: the CPU clock is stopped.
- `ST_PDOWN`: all clocks are stopped.
- `ST_WARMUP`: all clocks are stopped while the timed warm-up runs.

Its transitions are:
- enter-Power-down: ACTIVE to PDOWN.
- enter-Idle: ACTIVE to IDLE.
- irq-wake: IDLE to ACTIVE.
- external-wake: PDOWN to ACTIVE.
- timed-wake-start: PDOWN to WARMUP.
- warm-up-done: WARMUP to ACTIVE.
- any reset: back to ACTIVE.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a cold reset, `sfr_rdata` reads 0x10 (only bit 4, the power-off flag, set), both clock enables are 1, and `wake_pulse` is 0.
- R2: A warm reset clears every register bit except bit 4, which keeps its value, and it returns the block to the running state from any mode, with both clock enables at 1.
- R3: A write (`sfr_wr`=1 with `sfr_addr`=`REG_ADDR`) in the running state stores bits 7, 6, 5, 4, 3 and 2, which read back on `sfr_rdata` after the edge. A write to any other address changes nothing.
- R4: A write with bit 0 (Idle) = 1 and bit 1 = 0 enters Idle at the next edge. While in Idle, `cpu_clk_en` = 0, `per_clk_en` = 1 and bit 0 reads 1. `ext_wake` does not end Idle.
- R5: In Idle, `irq_pending` returns the block to the running state at the next edge. At that edge `cpu_clk_en` goes to 1, bit 0 reads 0, and `wake_pulse` is 1 for exactly one cycle.
- R6: A write with bit 1 (Power-down) = 1 enters Power-down at the next edge, even if bit 0 is also 1. Afterwards both clock enables are 0, bit 1 reads 1 and bit 0 reads 0.
- R7: In Power-down with bit 5 = 0, `ext_wake` returns the block to the running state at the next edge. At that edge both enables go to 1, bit 1 clears and `wake_pulse` pulses for one cycle. `irq_pending` alone does not end Power-down.
- R8: In Power-down with bit 5 = 1, `ext_wake` starts a warm-up. The clock enables stay 0 and bit 1 stays 1 until the `WARM_CYC`-th rising edge after the edge that sampled `ext_wake`. At that edge both enables return to 1 and `wake_pulse` pulses for one cycle.
- R9: A write made while `irq_pending` = 1 enters no low-power mode. Bits 1 and 0 read 0, the other bits are still stored, and `cpu_clk_en` stays 1.
- R10: Writes arriving while the block is in any low-power state are ignored, and the register reads unchanged after wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_cold_n | input | 1 | Power-up reset, active low, asynchronous |
| rst_warm_n | input | 1 | Warm reset, active low, asynchronous |
| sfr_addr | input | ADDR_W | Register bus address |
| sfr_wr | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Current register value (bits 1 and 0 reflect the mode) |
| irq_pending | input | 1 | An enabled interrupt is pending |
| ext_wake | input | 1 | External wake request for Power-down |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wake_pulse | output | 1 | One-cycle pulse on return to the running state |

## Verification
A wrong state register shows up at the clock enables and in bits 1 and 0 of `sfr_rdata` in the cycle after the faulty edge. For example, a missed Idle exit leaves `cpu_clk_en` low one cycle after `irq_pending` rises. A miscounting warm-up timer is exposed by checking that the enables are still low one edge before the expected return and high exactly on it. A power-off flag that is wrongly cleared by a warm reset is seen on the first read after that reset.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PDOWN  = 2'd2,
        ST_WARMUP = 2'd3
    } pwr_state_e;

    localparam int REG_W     = 8;
    localparam int B_BAUD2   = 7;
    localparam int B_FESEL   = 6;
    localparam int B_PDTIMED = 5;
    localparam int B_PWROFF  = 4;
    localparam int B_USR1    = 3;
    localparam int B_USR0    = 2;
    localparam int B_PDOWN   = 1;
    localparam int B_IDLE    = 0;

    localparam logic [REG_W-1:0] KEEP_MASK =
        REG_W'((1 << B_BAUD2) | (1 << B_FESEL) | (1 << B_PDTIMED) |
               (1 << B_USR1)  | (1 << B_USR0));

endpackage

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
    import pwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_cold_n,
    input  logic             rst_any_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             pd_flag,
    input  logic             idle_flag,
    output logic             pd_timed,
    output logic [REG_W-1:0] rdata
);

    logic [REG_W-1:0] keep_q;
    logic             pof_q;

    always_ff @(posedge clk or negedge rst_any_n) begin
        if (!rst_any_n) begin
            keep_q <= '0;
        end else if (wr_en) begin
            keep_q <= wdata & KEEP_MASK;
        end
    end

    // Power-off flag only sees the cold reset.
    always_ff @(posedge clk or negedge rst_cold_n) begin
        if (!rst_cold_n) begin
            pof_q <= 1'b1;
        end else if (wr_en && rst_any_n) begin
            pof_q <= wdata[B_PWROFF];
        end
    end

    always_comb begin
        rdata            = keep_q;
        rdata[B_PWROFF]  = pof_q;
        rdata[B_PDOWN]   = pd_flag;
        rdata[B_IDLE]    = idle_flag;
    end

    assign pd_timed = keep_q[B_PDTIMED];

    AST_POF_KEEP: assert property (@(posedge clk) disable iff (!rst_cold_n)
        !wr_en |=> $stable(pof_q)); // R2

endmodule

// File: rtl/pwr_warm_timer.sv
module pwr_warm_timer #(
    parameter int CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CNT_W = (CYC > 2) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_hit,
    input  logic       want_pd,
    input  logic       want_idle,
    input  logic       pd_timed,
    input  logic       irq_pending,
    input  logic       ext_wake,
    input  logic       warm_done,
    output pwr_state_e state,
    output logic       reg_wr,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       wake_pulse
);

    pwr_state_e nxt;

    assign reg_wr = addr_hit && (state == ST_ACTIVE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ACTIVE: begin
                if (reg_wr && !irq_pending) begin
                    if (want_pd)        nxt = ST_PDOWN;
                    else if (want_idle) nxt = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (irq_pending) nxt = ST_ACTIVE;
            end
            ST_PDOWN: begin
                if (ext_wake) nxt = pd_timed ? ST_WARMUP : ST_ACTIVE;
            end
            ST_WARMUP: begin
                if (warm_done) nxt = ST_ACTIVE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ACTIVE;
        else        state <= nxt;
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_clk_en <= 1'b1;
            per_clk_en <= 1'b1;
            wake_pulse <= 1'b0;
        end else begin
            cpu_clk_en <= (nxt == ST_ACTIVE);
            per_clk_en <= (nxt == ST_ACTIVE) || (nxt == ST_IDLE);
            wake_pulse <= (state != ST_ACTIVE) && (nxt == ST_ACTIVE);
        end
    end

    AST_IDLE_CLKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!cpu_clk_en && per_clk_en)); // R4
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && irq_pending) |=> (cpu_clk_en && wake_pulse)); // R5
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R5
    AST_PD_CLKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDOWN || state == ST_WARMUP) |-> (!cpu_clk_en && !per_clk_en)); // R6
    AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDOWN && !ext_wake) |=> (state == ST_PDOWN)); // R7
    AST_NO_ENTRY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && irq_pending) |=> cpu_clk_en); // R9

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40,
    parameter int              WARM_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_cold_n,
    input  logic              rst_warm_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [REG_W-1:0]  sfr_wdata,
    output logic [REG_W-1:0]  sfr_rdata,
    input  logic              irq_pending,
    input  logic              ext_wake,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              wake_pulse
);

    logic       rst_any_n;
    logic       addr_hit;
    logic       reg_wr;
    logic       pd_timed;
    logic       warm_done;
    pwr_state_e state;

    assign rst_any_n = rst_cold_n & rst_warm_n;
    assign addr_hit  = sfr_wr && (sfr_addr == REG_ADDR);

    pwr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_any_n),
        .addr_hit    (addr_hit),
        .want_pd     (sfr_wdata[B_PDOWN]),
        .want_idle   (sfr_wdata[B_IDLE]),
        .pd_timed    (pd_timed),
        .irq_pending (irq_pending),
        .ext_wake    (ext_wake),
        .warm_done   (warm_done),
        .state       (state),
        .reg_wr      (reg_wr),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .wake_pulse  (wake_pulse)
    );

    pwr_ctl_reg u_reg (
        .clk        (clk),
        .rst_cold_n (rst_cold_n),
        .rst_any_n  (rst_any_n),
        .wr_en      (reg_wr),
        .wdata      (sfr_wdata),
        .pd_flag    (state == ST_PDOWN || state == ST_WARMUP),
        .idle_flag  (state == ST_IDLE),
        .pd_timed   (pd_timed),
        .rdata      (sfr_rdata)
    );

    pwr_warm_timer #(.CYC(WARM_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_any_n),
        .run   (state == ST_WARMUP),
        .done  (warm_done)
    );

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;

    localparam logic [7:0] REG_ADDR = 8'h40;
    localparam int         WARM_CYC = 1024;

    logic       clk = 1'b0;
    logic       rst_cold_n = 1'b0;
    logic       rst_warm_n = 1'b0;
    logic [7:0] sfr_addr = '0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = '0;
    logic [7:0] sfr_rdata;
    logic       irq_pending = 1'b0;
    logic       ext_wake = 1'b0;
    logic       cpu_clk_en, per_clk_en, wake_pulse;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_keep = '0;
    logic       exp_pof  = 1'b1;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl #(.ADDR_W(8), .REG_ADDR(REG_ADDR), .WARM_CYC(WARM_CYC)) u_dut (
        .clk(clk), .rst_cold_n(rst_cold_n), .rst_warm_n(rst_warm_n),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .irq_pending(irq_pending), .ext_wake(ext_wake),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .wake_pulse(wake_pulse)
    );

    function automatic logic [7:0] exp_rd(input logic pd, input logic idl);
        return (exp_keep & 8'hEC) | {3'b0, exp_pof, 2'b0, pd, idl};
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic warm_reset();
        @(negedge clk); rst_warm_n = 1'b0;
        @(negedge clk); rst_warm_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_running(input string rq);
        check(rq, {cpu_clk_en, per_clk_en}, 2'b11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_cold_n = 1'b1; rst_warm_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", sfr_rdata, 8'h10);
        check_running("R1 clocks");
        check("R1 wake", wake_pulse, 0);

        // R3 other address ignored, then stored bits
        wr(8'hFF, 8'hFC);
        check("R3 wrong addr", sfr_rdata, 8'h10);
        wr(REG_ADDR, 8'hEC);
        check("R3 stored", sfr_rdata, 8'hEC);

        // R2 warm reset keeps power-off flag
        warm_reset();
        check("R2 pof kept 0", sfr_rdata, 8'h00);
        wr(REG_ADDR, 8'hFC & 8'hF0 | 8'h10);
        warm_reset();
        check("R2 pof kept 1", sfr_rdata, 8'h10);
        exp_keep = '0; exp_pof = 1'b1;

        // R10 write during idle ignored
        wr(REG_ADDR, 8'h11);
        check("R4 idle entered", sfr_rdata, 8'h11);
        wr(REG_ADDR, 8'h08);
        @(negedge clk); irq_pending = 1'b1;
        @(negedge clk); irq_pending = 1'b0;
        check("R10 write ignored", sfr_rdata, 8'h10);

        // R2 warm reset ends idle
        wr(REG_ADDR, 8'h11);
        check("R4 cpu off", cpu_clk_en, 0);
        warm_reset();
        check_running("R2 idle ended");
        check("R2 rdata", sfr_rdata, 8'h10);

        // R6 priority: both mode bits set
        wr(REG_ADDR, 8'h13);
        check("R6 priority", sfr_rdata, 8'h12);
        check("R6 clocks", {cpu_clk_en, per_clk_en}, 2'b00);
        @(negedge clk); ext_wake = 1'b1;
        @(negedge clk); ext_wake = 1'b0;
        check_running("R7 wake");

        for (int i = 0; i < 40; i++) begin
            logic [7:0] d;
            logic       irq;
            int         mode;
            d   = 8'($urandom);
            irq = ($urandom % 4) == 0;
            @(negedge clk);
            irq_pending = irq; sfr_addr = REG_ADDR; sfr_wdata = d; sfr_wr = 1'b1;
            @(negedge clk);
            sfr_wr = 1'b0; irq_pending = 1'b0;
            exp_keep = d & 8'hEC; exp_pof = d[4];
            mode = irq ? 0 : (d[1] ? 2 : (d[0] ? 1 : 0));
            check(irq ? "R9 rdata" : "R3 rdata", sfr_rdata, exp_rd(mode == 2, mode == 1));
            check("R9 R4 R6 cpu", cpu_clk_en, mode == 0);
            check("R4 R6 per", per_clk_en, mode != 2);
            if (mode == 1) begin
                @(negedge clk); ext_wake = 1'b1;
                @(negedge clk); ext_wake = 1'b0;
                check("R4 ext_wake ignored", cpu_clk_en, 0);
                irq_pending = 1'b1;
                @(negedge clk); irq_pending = 1'b0;
                check("R5 cpu back", cpu_clk_en, 1);
                check("R5 pulse", wake_pulse, 1);
                check("R5 bit cleared", sfr_rdata, exp_rd(0, 0));
                @(negedge clk);
                check("R5 single pulse", wake_pulse, 0);
            end else if (mode == 2) begin
                irq_pending = 1'b1;
                @(negedge clk); irq_pending = 1'b0;
                check("R7 irq ignored", {cpu_clk_en, per_clk_en}, 2'b00);
                ext_wake = 1'b1;
                @(negedge clk); ext_wake = 1'b0;
                if (!d[5]) begin
                    check_running("R7 clocks back");
                    check("R7 pulse", wake_pulse, 1);
                    check("R7 bit cleared", sfr_rdata, exp_rd(0, 0));
                end else begin
                    check("R8 still off", cpu_clk_en, 0);
                    repeat (WARM_CYC - 1) @(negedge clk);
                    check("R8 off before end", {cpu_clk_en, per_clk_en}, 2'b00);
                    check("R8 bit held", sfr_rdata, exp_rd(1, 0));
                    @(negedge clk);
                    check_running("R8 clocks back");
                    check("R8 pulse", wake_pulse, 1);
                    check("R8 bit cleared", sfr_rdata, exp_rd(0, 0));
                end
                @(negedge clk);
                check("R7 R8 single pulse", wake_pulse, 0);
            end
        end

        // R1 cold reset sets power-off flag again
        wr(REG_ADDR, 8'h00);
        @(negedge clk); rst_cold_n = 1'b0;
        @(negedge clk); rst_cold_n = 1'b1;
        @(negedge clk);
        check("R1 cold pof", sfr_rdata, 8'h10);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule